// File: doc/BRIEF.md
# Effective Address Generation Unit

This block executes the memory half of a load or store instruction. It takes one 32-bit memory-reference instruction on a start strobe and adds the zero-extended 20-bit address field to the value of the selected index register. In direct mode that sum is the effective address. In indirect mode the unit first reads the memory word at that sum and uses the word as the effective address. It then performs the operand access: a load writes memory into a destination register, and a store writes a source register into memory.

The unit owns an eight-entry register file. Register zero always reads as zero and ignores writes. Indexing is never bypassed. An index of zero therefore gives plain direct or plain indirect addressing, and an address field of zero with indirect set makes the index register a pointer to a pointer. Memory is a single synchronous port. A request holds its address, write enable and write data until the memory answers with ready. Load data is valid on the read-data input in the ready cycle.

Top module: `ea_unit`

## Requirements
- R1: Instruction fields are: bit 27 (the low opcode bit) selects store when 1 and load when 0. Bit 26 is the indirect flag, bits 25:23 the data register (destination or source), bits 22:20 the index register, and bits 19:0 the address field. Opcode bits 31:28 are ignored.
- R2: The first address is the address field zero-extended, plus the full index register value, truncated to ADDR_W (16) bits.
- R3: With the indirect flag clear, the effective address equals the first address and exactly one memory access is made.
- R4: With the indirect flag set, the unit reads memory at the first address. The low ADDR_W bits of the returned word become the effective address, and the operand access follows.
- R5: A load writes M[EA] into the destination register and onto `load_data`. A store writes the source register value to M[EA].
- R6: Register zero reads as zero at all times. A load that targets it leaves it zero.
- R7: During a memory step, `mem_req`, `mem_addr` and `mem_we` stay stable until `mem_ready` is high at a clock edge. The step completes at that edge.
- R8: Sequence timing: one address-calculation cycle follows the start edge. Each memory step lasts its wait cycles plus one. `done` is high for exactly one cycle directly after the final transfer, with no request active.
- R9: `start` and `instr` are ignored while the unit is busy, including the `done` cycle.
- R10: In the `done` cycle, `ea_out` shows the effective address. After a load, `load_data` shows the loaded word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin executing `instr` (sampled when idle) |
| instr | input | 32 | Memory-reference instruction |
| mem_req | output | 1 | Memory request active |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Store data |
| mem_rdata | input | DATA_W | Read data, valid with `mem_ready` |
| mem_ready | input | 1 | Current request completes at this edge |
| ea_out | output | ADDR_W | Effective address |
| load_data | output | DATA_W | Last loaded word |
| done | output | 1 | One-cycle completion pulse |

## Verification
Assertions check on every cycle that a waiting request holds still, and that the pointer word becomes the next address after an indirect read. They also check that a direct calculation goes straight to the operand access, that `done` is a lone pulse with no request, that the latched instruction is frozen while busy, and that register zero reads zero. Only the bench scenarios can show the arithmetic outcome of whole instructions. These include the worked pre-indexed indirect case, pointer-to-pointer use with a zero address field, truncation of wide sums, and discarded writes to register zero. They also show the exact cycle trace under different memory wait lengths.

// File: rtl/ea_pkg.sv
// Package: shared encodings for the effective address unit.
// Assumes the 32-bit instruction layout fixed by the block's requirements.
package ea_pkg;
    localparam int INSTR_W = 32;
    localparam int FIELD_W = 20;
    localparam int REG_AW  = 3;
    localparam int NREG    = 1 << REG_AW;

    // Decoded view of one memory-reference instruction (bit 31 first).
    typedef struct packed {
        logic [3:0]         op_hi;
        logic               is_store;
        logic               indirect;
        logic [REG_AW-1:0]  data_reg;
        logic [REG_AW-1:0]  index_reg;
        logic [FIELD_W-1:0] afield;
    } instr_t;

    // Controller states.
    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_CALC = 3'd1,
        S_PTR  = 3'd2,
        S_ACC  = 3'd3,
        S_DONE = 3'd4
    } state_t;
endpackage

// File: rtl/ea_regfile.sv
// Module: ea_regfile
// Register file with two combinational read ports and one write port.
// Entry zero has no storage: it reads as zero and ignores writes.
// Assumes NREG is a power of two matching the address width.
module ea_regfile #(
    parameter int DATA_W = 32,
    parameter int NREG   = 8,
    localparam int AW    = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     ra_addr,
    output logic [DATA_W-1:0] ra_data,
    input  logic [AW-1:0]     rb_addr,
    output logic [DATA_W-1:0] rb_data,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata
);
    logic [DATA_W-1:0] store_q [1:NREG-1];

    // Storage for entries 1..NREG-1, cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 1; i < NREG; i++) store_q[i] <= '0;
        end else if (we && waddr != '0) begin
            store_q[waddr] <= wdata;
        end
    end

    // Read ports; entry zero forced to zero.
    always_comb begin
        ra_data = (ra_addr == '0) ? '0 : store_q[ra_addr];
        rb_data = (rb_addr == '0) ? '0 : store_q[rb_addr];
    end
endmodule

// File: rtl/ea_addr_calc.sv
// Module: ea_addr_calc
// Adds the zero-extended address field to the index value and keeps
// the low ADDR_W bits. Assumes FIELD_W <= DATA_W and ADDR_W <= DATA_W.
module ea_addr_calc #(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 16,
    parameter int FIELD_W = 20
) (
    input  logic [FIELD_W-1:0] afield,
    input  logic [DATA_W-1:0]  index_val,
    output logic [ADDR_W-1:0]  first_addr
);
    logic [DATA_W-1:0] sum;

    // Full-width sum, then truncation to the memory address width.
    always_comb begin
        sum        = DATA_W'(afield) + index_val;
        first_addr = sum[ADDR_W-1:0];
    end
endmodule

// File: rtl/ea_ctrl.sv
// Module: ea_ctrl
// Sequencer: IDLE -> CALC -> (PTR if indirect) -> ACC -> DONE -> IDLE.
// Latches the instruction at start and ignores start while busy.
// Each memory step waits for mem_ready. Assumes the register file read
// ports are combinational.
module ea_ctrl
    import ea_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [INSTR_W-1:0] instr,
    input  logic [ADDR_W-1:0]  first_addr,
    input  logic [DATA_W-1:0]  src_val,
    output instr_t             instr_q,
    output logic               mem_req,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic [DATA_W-1:0]  mem_rdata,
    input  logic               mem_ready,
    output logic               rf_we,
    output logic [REG_AW-1:0]  rf_waddr,
    output logic [DATA_W-1:0]  rf_wdata,
    output logic [ADDR_W-1:0]  ea_out,
    output logic [DATA_W-1:0]  load_data,
    output logic               done
);
    state_t            state;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] load_q;

    // State, address and load-data registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            instr_q <= '0;
            addr_q  <= '0;
            load_q  <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    instr_q <= instr_t'(instr);
                    state   <= S_CALC;
                end
                S_CALC: begin
                    addr_q <= first_addr;
                    state  <= instr_q.indirect ? S_PTR : S_ACC;
                end
                S_PTR: if (mem_ready) begin
                    addr_q <= mem_rdata[ADDR_W-1:0];
                    state  <= S_ACC;
                end
                S_ACC: if (mem_ready) begin
                    if (!instr_q.is_store) load_q <= mem_rdata;
                    state <= S_DONE;
                end
                S_DONE: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Memory port, register write-back and status outputs.
    always_comb begin
        mem_req   = (state == S_PTR) || (state == S_ACC);
        mem_we    = (state == S_ACC) && instr_q.is_store;
        mem_addr  = addr_q;
        mem_wdata = src_val;
        rf_we     = (state == S_ACC) && mem_ready && !instr_q.is_store;
        rf_waddr  = instr_q.data_reg;
        rf_wdata  = mem_rdata;
        ea_out    = addr_q;
        load_data = load_q;
        done      = (state == S_DONE);
    end

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R4
    ptr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PTR && mem_ready) |=> (mem_addr == $past(mem_rdata[ADDR_W-1:0]) && state == S_ACC));

    // R3
    direct_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CALC && !instr_q.indirect) |=> (state == S_ACC && mem_addr == $past(first_addr)));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);

    // R9
    busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) |=> $stable(instr_q));
endmodule

// File: rtl/ea_unit.sv
// Module: ea_unit (top)
// Effective address generation with pre-indexed indirect support.
// Instantiates the register file, the address adder and the sequencer.
// Assumes a single synchronous memory port with a ready handshake.
module ea_unit
    import ea_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [INSTR_W-1:0] instr,
    output logic               mem_req,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic [DATA_W-1:0]  mem_rdata,
    input  logic               mem_ready,
    output logic [ADDR_W-1:0]  ea_out,
    output logic [DATA_W-1:0]  load_data,
    output logic               done
);
    instr_t            instr_q;
    logic [DATA_W-1:0] idx_val;
    logic [DATA_W-1:0] src_val;
    logic [ADDR_W-1:0] first_addr;
    logic              rf_we;
    logic [REG_AW-1:0] rf_waddr;
    logic [DATA_W-1:0] rf_wdata;

    ea_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_addr (instr_q.index_reg),
        .ra_data (idx_val),
        .rb_addr (instr_q.data_reg),
        .rb_data (src_val),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata)
    );

    ea_addr_calc #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .FIELD_W(FIELD_W)) u_calc (
        .afield     (instr_q.afield),
        .index_val  (idx_val),
        .first_addr (first_addr)
    );

    ea_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .instr      (instr),
        .first_addr (first_addr),
        .src_val    (src_val),
        .instr_q    (instr_q),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .mem_ready  (mem_ready),
        .rf_we      (rf_we),
        .rf_waddr   (rf_waddr),
        .rf_wdata   (rf_wdata),
        .ea_out     (ea_out),
        .load_data  (load_data),
        .done       (done)
    );

    // R6
    r0_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_q.index_reg == '0) |-> (idx_val == '0));

    // R5
    load_writeback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && rf_waddr != '0) |=> (src_val == $past(rf_wdata)));
endmodule

// File: tb/tb_ea_unit.sv
// Bench: behavioural reference model (register array, sparse memory,
// per-cycle expected trace queues) compared with the design every clock.
module tb_ea_unit;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [31:0]       instr = '0;
    logic              mem_req, mem_we, done;
    logic [ADDR_W-1:0] mem_addr, ea_out;
    logic [DATA_W-1:0] mem_wdata, load_data;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic              mem_ready = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    int wait_cfg = 0;
    int wcnt     = 0;
    int cycles   = 0;

    logic [31:0] mem [int];
    logic [31:0] ref_rf [8];

    bit q_req[$];
    bit q_we[$];
    bit q_done[$];
    int q_addr[$];

    ea_unit #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .ea_out(ea_out), .load_data(load_data), .done(done)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] rd(int a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // R1: bit27 store, bit26 indirect, [25:23] data reg, [22:20] index, [19:0] field
    function automatic logic [31:0] mk(bit st, bit ind, int d, int x, int af);
        return {4'b0101, st, ind, 3'(d), 3'(x), 20'(af)};
    endfunction

    task automatic chk(string req, string what, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Memory environment: ready after wait_cfg cycles, read data at negedge.
    always @(negedge clk) begin
        if (!mem_req) begin
            wcnt = 0;
            mem_ready = 1'b0;
        end else begin
            if (mem_ready) wcnt = 0;
            mem_ready = (wcnt >= wait_cfg);
            if (!mem_ready) wcnt++;
        end
        mem_rdata = rd(int'(mem_addr));
    end

    always @(posedge clk) begin
        if (mem_req && mem_we && mem_ready) mem[int'(mem_addr)] = mem_wdata;
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++;
            n_checks++;
            $display("FAIL R8 watchdog: actual %0d expected <100000", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic push(bit r, bit w, bit dn, int a);
        q_req.push_back(r);
        q_we.push_back(w);
        q_done.push_back(dn);
        q_addr.push_back(a);
    endtask

    // Run one instruction against the reference model, cycle by cycle.
    task automatic exec(bit st, bit ind, int d, int x, int af, int w, bit noise);
        int a1, ea, n;
        logic [31:0] data;
        wait_cfg = w;
        a1 = int'((32'(af) + ref_rf[x]) & 32'hFFFF);          // R2
        ea = ind ? int'(rd(a1) & 32'hFFFF) : a1;              // R3, R4
        push(0, 0, 0, 0);                                     // CALC cycle
        if (ind) for (int k = 0; k <= w; k++) push(1, 0, 0, a1);
        for (int k = 0; k <= w; k++) push(1, st, 0, ea);
        push(0, 0, 1, 0);                                     // DONE cycle
        n = q_req.size();
        @(negedge clk);
        instr = mk(st, ind, d, x, af);
        start = 1'b1;
        for (int k = 0; k < n; k++) begin
            bit er, ew, ed;
            int eaddr;
            @(negedge clk);
            er = q_req.pop_front();
            ew = q_we.pop_front();
            ed = q_done.pop_front();
            eaddr = q_addr.pop_front();
            chk("R8", "trace done", done, ed);
            chk("R7", "trace req", mem_req, er);
            if (er) begin
                chk("R7", "trace we", mem_we, ew);
                chk("R4", "trace addr", mem_addr, eaddr);
            end
            // R9: garbage on the inputs while busy
            start = noise && (k < n - 1);
            instr = noise ? 32'hFFFF_FFFF : mk(st, ind, d, x, af);
            if (ed) begin
                chk("R10", "ea_out", ea_out, ea);
                if (!st) chk("R10", "load_data", load_data, rd(ea));
            end
        end
        start = 1'b0;
        // Update the reference model.
        if (st) begin
            data = ref_rf[d];
            chk("R5", "stored word", rd(ea), data);
        end else if (d != 0) begin
            ref_rf[d] = rd(ea);                               // R6: R0 never written
        end
        @(negedge clk);
        chk("R8", "idle after done", done, 0);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) ref_rf[i] = 32'h0;
        // Worked memory image.
        mem[5] = 32'h11; mem[6] = 32'h32; mem[7] = 32'h2C; mem[8] = 32'h1E;
        mem[9] = 32'h56; mem[10] = 32'h05; mem[11] = 32'h7A; mem[12] = 32'h09;
        mem[13] = 32'h03; mem[14] = 32'h0F; mem[15] = 32'h0E; mem[16] = 32'h0D;
        mem[17] = 32'h08;
        mem[32'h100] = 32'h4;
        mem[32'h101] = 32'h7;
        mem[32'h102] = 32'h0001_0010;
        mem[32'h103] = 32'h40;
        mem[32'h40]  = 32'h0B;
        mem[32'h500] = 32'hABCD_0006;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8", "reset done", done, 0);
        chk("R7", "reset req", mem_req, 0);
        chk("R10", "reset ea_out", ea_out, 0);
        chk("R10", "reset load_data", load_data, 0);

        // R5: preload registers through loads, various waits
        exec(0, 0, 3, 0, 32'h100, 0, 0);
        exec(0, 0, 7, 0, 32'h101, 1, 0);
        exec(0, 0, 2, 0, 32'h102, 2, 0);
        exec(0, 0, 6, 0, 32'h103, 0, 0);
        // R2, R3: indexed direct, 0x0A + 4 -> 0x0E
        exec(0, 0, 1, 3, 32'h0A, 1, 0);
        // R4: pre-indexed indirect, 0x0A + 7 -> M[0x11] = 0x08
        exec(0, 1, 1, 7, 32'h0A, 2, 0);
        // R3: index zero is plain direct
        exec(0, 0, 4, 0, 32'h0C, 0, 0);
        // R4: indirect with index zero is plain indirect
        exec(0, 1, 4, 0, 32'h0A, 3, 0);
        // R4: zero field, register as pointer to pointer
        exec(0, 1, 5, 6, 32'h0, 1, 0);
        // R2: truncation 0xFFFF5 + 0x10010 -> 0x0005
        exec(0, 0, 5, 2, 32'hFFFF5, 0, 0);
        // R4: pointer word upper bits dropped
        exec(0, 1, 1, 0, 32'h500, 1, 0);
        // R5: stores direct and indirect, then read back
        exec(1, 0, 3, 3, 32'h200, 0, 0);
        exec(1, 1, 7, 3, 32'h0, 2, 0);
        exec(0, 0, 4, 0, 32'h204, 1, 0);
        // R6: load into R0 is discarded, store R0 writes zero
        exec(0, 0, 0, 0, 32'h0E, 0, 0);
        exec(1, 0, 0, 0, 32'h300, 0, 0);
        chk("R6", "R0 stored", rd(32'h300), 0);
        // R9: start and instr noise while busy
        exec(0, 1, 2, 7, 32'h0A, 2, 1);
        exec(1, 0, 2, 0, 32'h310, 0, 1);
        chk("R9", "no extra request", mem_req, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule